// File: doc/BRIEF.md
# AU-4 Pointer Tracker

This block follows the pointer carried in the H1/H2 bytes of an incoming STM-1 byte stream. From that pointer it finds where the VC-4 begins. The caller gives it each byte together with the row and column of that byte in the 9 x 270 frame. The block reads the first H1 byte and the first H2 byte of the pointer row. It sorts each 16-bit pointer word into one of these kinds: normal, increment, decrement, new-data-flag, new candidate, all-ones or invalid. It then moves a three-state machine (normal, path AIS, loss of pointer) and keeps the accepted pointer value.

While the machine is in the normal state, the block marks two kinds of byte on its byte input. It marks the J1 byte. It also marks every byte that belongs to the VC-4, and this accounts for the positive-stuff bytes and the negative-opportunity bytes of the current frame. Positive justifications, negative justifications and new-data-flag acceptances each feed an 8-bit counter. A counter stops at 255 and clears when its read strobe is pulsed.

The byte input uses a valid/ready pair. `in_ready` follows `en` and the block never applies back-pressure while enabled. A byte offered while `in_ready` is low is dropped without any effect on state. The caller keeps the frame timing and may skip bytes by holding `in_valid` low. The block reads row and column only from the bytes it accepts.

Top module: `au4_ptr_tracker`

## Requirements
- R1: After reset `lop` is 1, `path_ais` is 0, `ptr_out` is 0, all three counters are 0, and both markers are low.
- R2: While `en` is 0, `in_ready` is 0, both markers are 0, and offered bytes change neither the state, the pointer nor the counters.
- R3: The pointer word is {H1,H2}. It is taken from row 3, column 0 (H1) and row 3, column 3 (H2). Bits [15:12] are the flag nibble, [11:10] the size bits and [9:0] the pointer, which is valid from 0 to 782. A normal flag nibble is within one bit of 0110. A normal-flag pointer in range that differs from the current pointer, or any such pointer outside the normal state, is a candidate. Three identical candidates in a row are accepted, and acceptance sets the normal state.
- R4: In the normal state, take a normal-flag word whose value differs from the current pointer. If 3 or more of the odd bits (9,7,5,3,1) are inverted and fewer than 3 even bits are, the word is an increment. If 3 or more of the even bits are inverted and fewer than 3 odd bits are, it is a decrement. The pointer steps by one and wraps between 782 and 0. The positive or negative counter then counts up.
- R5: A flag nibble within one bit of 1001 with a pointer of 782 or less is accepted at once in any state. It sets the normal state and counts up the new-data-flag counter.
- R6: When `ss_chk_en` is 1, a word whose size bits differ from the expected value is invalid. The expected value is 2'b10, or `ss_prog` when `ss_sel_prog` is 1. When `ss_chk_en` is 0 the size bits are ignored.
- R7: Eight invalid words in a row, counted with no other word between them, move the normal state to loss of pointer.
- R8: Three all-ones words in a row move any state to path AIS. Eight invalid words in a row move path AIS to loss of pointer, unless `ais_lop_dis` is 1, in which case the state stays at path AIS.
- R9: In the normal state, `j1_mark` is high for the byte at payload offset 3*pointer. That offset is counted from row 3, column 9 along the 261 payload columns and wraps from row 8 to row 0. `j1_mark` is low in the other states.
- R10: In the normal state, `spe_mark` is high for columns 9 and above. Two exceptions hold in row 3 between the H2 byte and the next column-0 byte. After an increment, columns 9 to 11 are low. After a decrement, columns 6 to 8 are high.
- R11: Each counter stops at 255. A read strobe clears its counter, and an event in the same cycle as the strobe leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Tracker enable |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted (mirrors en) |
| in_data | input | 8 | Stream byte |
| in_row | input | 4 | Row of the byte, 0..8 |
| in_col | input | 9 | Column of the byte, 0..269 |
| ss_chk_en | input | 1 | Enable size-bit check |
| ss_sel_prog | input | 1 | Use ss_prog as expected size bits |
| ss_prog | input | 2 | Programmable size bits |
| ais_lop_dis | input | 1 | Block the AIS to LOP step |
| rd_pj | input | 1 | Read/clear positive counter |
| rd_nj | input | 1 | Read/clear negative counter |
| rd_ndf | input | 1 | Read/clear new-data-flag counter |
| j1_mark | output | 1 | Current byte is J1 |
| spe_mark | output | 1 | Current byte belongs to the VC-4 |
| path_ais | output | 1 | Path AIS state |
| lop | output | 1 | Loss-of-pointer state |
| ptr_out | output | 10 | Accepted pointer |
| pj_cnt | output | 8 | Positive justification count |
| nj_cnt | output | 8 | Negative justification count |
| ndf_cnt | output | 8 | New-data-flag count |

## Verification
The bench drives pointer words of known kinds against a reference of the classification and state rules. The words are a steady pointer, odd-bit and even-bit inversions, flagged jumps, repeated and broken candidate runs, all-ones words, bad size bits, out-of-range values and random garbage. Steady-pointer and inversion words show whether the majority vote separates normal, increment and decrement. Runs of candidates that are broken early show whether the three-in-a-row rule uses a count that is reset. Mixed runs of invalid and all-ones words under both settings of the AIS-to-LOP control show which alarm path is taken. Probes at the computed J1 byte, at its neighbours and at the justification bytes show whether the markers follow the pointer and the stuff.

// File: rtl/au4_ptr_pkg.sv
package au4_ptr_pkg;
  typedef enum logic [1:0] {ST_NORM, ST_AIS, ST_LOP} trk_state_e;
  typedef enum logic [2:0] {
    W_INV, W_AIS, W_NORM, W_INC, W_DEC, W_NDF, W_NEW
  } wcls_e;
  localparam logic [3:0] FLAG_NORMAL = 4'b0110;
  localparam logic [3:0] FLAG_NEWDAT = 4'b1001;
  localparam logic [1:0] SS_FIXED    = 2'b10;
endpackage

// File: rtl/au4_ptr_classify.sv
module au4_ptr_classify
  import au4_ptr_pkg::*;
#(
  parameter int PTR_W   = 10,
  parameter int MAX_PTR = 782
) (
  input  logic [7:0]       h1,
  input  logic [7:0]       h2,
  input  logic [PTR_W-1:0] cur,
  input  logic             in_norm,
  input  logic             ss_chk_en,
  input  logic             ss_sel_prog,
  input  logic [1:0]       ss_prog,
  output wcls_e            cls,
  output logic [PTR_W-1:0] val
);
  logic [15:0]      word;
  logic [3:0]       flags;
  logic [1:0]       ss_exp;
  logic [PTR_W-1:0] dif;
  logic [3:0]       odd_inv, even_inv;
  logic             in_range, flag_ndf, flag_norm, ss_bad;

  assign word     = {h1, h2};
  assign flags    = word[15:12];
  assign val      = word[PTR_W-1:0];
  assign ss_exp   = ss_sel_prog ? ss_prog : SS_FIXED;
  assign ss_bad   = ss_chk_en && (word[11:10] != ss_exp);
  assign in_range = (val <= PTR_W'(MAX_PTR));
  assign flag_ndf  = ($countones(flags ^ FLAG_NEWDAT) <= 1);
  assign flag_norm = ($countones(flags ^ FLAG_NORMAL) <= 1);
  assign dif      = val ^ cur;

  always_comb begin
    odd_inv  = '0;
    even_inv = '0;
    for (int b = 0; b < PTR_W; b++) begin
      if (dif[b]) begin
        if (b % 2 == 1) odd_inv  = odd_inv + 4'd1;
        else            even_inv = even_inv + 4'd1;
      end
    end
  end

  always_comb begin
    cls = W_INV;
    if (word == 16'hFFFF)          cls = W_AIS;
    else if (ss_bad)               cls = W_INV;
    else if (flag_ndf)             cls = in_range ? W_NDF : W_INV;
    else if (!flag_norm)           cls = W_INV;
    else if (in_norm && dif == '0) cls = W_NORM;
    else if (in_norm && odd_inv >= 4'd3 && even_inv < 4'd3)  cls = W_INC;
    else if (in_norm && even_inv >= 4'd3 && odd_inv < 4'd3)  cls = W_DEC;
    else                           cls = in_range ? W_NEW : W_INV;
  end
endmodule

// File: rtl/au4_ptr_fsm.sv
module au4_ptr_fsm
  import au4_ptr_pkg::*;
#(
  parameter int PTR_W     = 10,
  parameter int MAX_PTR   = 782,
  parameter int INV_LIMIT = 8,
  parameter int NEW_LIMIT = 3,
  parameter int AIS_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  wcls_e            cls,
  input  logic [PTR_W-1:0] val,
  input  logic             ais_lop_dis,
  output trk_state_e       state,
  output logic [PTR_W-1:0] cur,
  output logic             pj_evt,
  output logic             nj_evt,
  output logic             ndf_evt
);
  localparam int INV_CW = $clog2(INV_LIMIT + 1);
  localparam int NEW_CW = $clog2(NEW_LIMIT + 1);
  localparam int AIS_CW = $clog2(AIS_LIMIT + 1);

  trk_state_e       state_n;
  logic [PTR_W-1:0] cur_n, cand, cand_n;
  logic [INV_CW-1:0] inv_c, inv_n;
  logic [NEW_CW-1:0] new_c, new_n;
  logic [AIS_CW-1:0] ais_c, ais_n;

  always_comb begin
    state_n = state;
    cur_n   = cur;
    cand_n  = cand;
    inv_n   = inv_c;
    new_n   = new_c;
    ais_n   = ais_c;
    pj_evt  = 1'b0;
    nj_evt  = 1'b0;
    ndf_evt = 1'b0;
    if (step) begin
      unique case (cls)
        W_AIS: begin
          inv_n = '0;
          new_n = '0;
          if (ais_c != AIS_CW'(AIS_LIMIT)) ais_n = ais_c + 1'b1;
          if (ais_n == AIS_CW'(AIS_LIMIT)) state_n = ST_AIS;
        end
        W_INV: begin
          ais_n = '0;
          new_n = '0;
          if (inv_c != INV_CW'(INV_LIMIT)) inv_n = inv_c + 1'b1;
          if (inv_n == INV_CW'(INV_LIMIT)) begin
            if (state == ST_NORM || (state == ST_AIS && !ais_lop_dis))
              state_n = ST_LOP;
          end
        end
        W_NORM: begin
          inv_n = '0; new_n = '0; ais_n = '0;
        end
        W_INC: begin
          inv_n = '0; new_n = '0; ais_n = '0;
          cur_n  = (cur == PTR_W'(MAX_PTR)) ? '0 : cur + 1'b1;
          pj_evt = 1'b1;
        end
        W_DEC: begin
          inv_n = '0; new_n = '0; ais_n = '0;
          cur_n  = (cur == '0) ? PTR_W'(MAX_PTR) : cur - 1'b1;
          nj_evt = 1'b1;
        end
        W_NDF: begin
          inv_n = '0; new_n = '0; ais_n = '0;
          cur_n   = val;
          state_n = ST_NORM;
          ndf_evt = 1'b1;
        end
        W_NEW: begin
          inv_n  = '0; ais_n = '0;
          new_n  = (val == cand && new_c != '0) ? new_c + 1'b1 : NEW_CW'(1);
          cand_n = val;
          if (new_n == NEW_CW'(NEW_LIMIT)) begin
            cur_n   = val;
            state_n = ST_NORM;
            new_n   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOP;
      cur   <= '0;
      cand  <= '0;
      inv_c <= '0;
      new_c <= '0;
      ais_c <= '0;
    end else begin
      state <= state_n;
      cur   <= cur_n;
      cand  <= cand_n;
      inv_c <= inv_n;
      new_c <= new_n;
      ais_c <= ais_n;
    end
  end
endmodule

// File: rtl/au4_evt_counter.sv
module au4_evt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= inc ? CNT_W'(1) : '0;
    else if (inc && ~&cnt)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/au4_j1_locator.sv
module au4_j1_locator #(
  parameter int PTR_W    = 10,
  parameter int ROWS     = 9,
  parameter int COLS     = 270,
  parameter int TOH_COLS = 9,
  parameter int PTR_ROW  = 3,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 9
) (
  input  logic [PTR_W-1:0] cur,
  output logic [ROW_W-1:0] j1_row,
  output logic [COL_W-1:0] j1_col
);
  localparam int PAY_COLS = COLS - TOH_COLS;
  logic [15:0] lin, quo, rem, rsum;

  always_comb begin
    lin    = 16'(cur) * 16'd3;
    quo    = lin / 16'(PAY_COLS);
    rem    = lin % 16'(PAY_COLS);
    rsum   = 16'(PTR_ROW) + quo;
    j1_row = ROW_W'((rsum >= 16'(ROWS)) ? rsum - 16'(ROWS) : rsum);
    j1_col = COL_W'(16'(TOH_COLS) + rem);
  end
endmodule

// File: rtl/au4_ptr_tracker.sv
module au4_ptr_tracker
  import au4_ptr_pkg::*;
#(
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int TOH_COLS  = 9,
  parameter int PTR_ROW   = 3,
  parameter int PTR_W     = 10,
  parameter int MAX_PTR   = 782,
  parameter int CNT_W     = 8,
  parameter int INV_LIMIT = 8,
  parameter int NEW_LIMIT = 3,
  parameter int AIS_LIMIT = 3,
  parameter int ROW_W     = $clog2(ROWS),
  parameter int COL_W     = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic             ss_chk_en,
  input  logic             ss_sel_prog,
  input  logic [1:0]       ss_prog,
  input  logic             ais_lop_dis,
  input  logic             rd_pj,
  input  logic             rd_nj,
  input  logic             rd_ndf,
  output logic             j1_mark,
  output logic             spe_mark,
  output logic             path_ais,
  output logic             lop,
  output logic [PTR_W-1:0] ptr_out,
  output logic [CNT_W-1:0] pj_cnt,
  output logic [CNT_W-1:0] nj_cnt,
  output logic [CNT_W-1:0] ndf_cnt
);
  localparam int H1_COL   = 0;
  localparam int H2_COL   = H1_COL + 3;
  localparam int N_CNT    = 3;

  logic             accept, at_h1, at_h2, in_norm;
  logic [7:0]       h1_q;
  wcls_e            cls;
  logic [PTR_W-1:0] val, cur;
  trk_state_e       state;
  logic             pj_evt, nj_evt, ndf_evt;
  logic             pj_now, nj_now;
  logic [ROW_W-1:0] j1_row;
  logic [COL_W-1:0] j1_col;
  logic [N_CNT-1:0] evt, clr;
  logic [CNT_W-1:0] cnt [N_CNT];
  logic             in_pay, pos_stuff, neg_opp;

  assign in_ready = en;
  assign accept   = in_valid && en;
  assign at_h1    = accept && in_row == ROW_W'(PTR_ROW) && in_col == COL_W'(H1_COL);
  assign at_h2    = accept && in_row == ROW_W'(PTR_ROW) && in_col == COL_W'(H2_COL);
  assign in_norm  = (state == ST_NORM);

  always_ff @(posedge clk) begin
    if (!rst_n)     h1_q <= '0;
    else if (at_h1) h1_q <= in_data;
  end

  au4_ptr_classify #(.PTR_W(PTR_W), .MAX_PTR(MAX_PTR)) cls_i (
    .h1(h1_q), .h2(in_data), .cur(cur), .in_norm(in_norm),
    .ss_chk_en(ss_chk_en), .ss_sel_prog(ss_sel_prog), .ss_prog(ss_prog),
    .cls(cls), .val(val)
  );

  au4_ptr_fsm #(
    .PTR_W(PTR_W), .MAX_PTR(MAX_PTR), .INV_LIMIT(INV_LIMIT),
    .NEW_LIMIT(NEW_LIMIT), .AIS_LIMIT(AIS_LIMIT)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .step(at_h2), .cls(cls), .val(val),
    .ais_lop_dis(ais_lop_dis), .state(state), .cur(cur),
    .pj_evt(pj_evt), .nj_evt(nj_evt), .ndf_evt(ndf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pj_now <= 1'b0;
      nj_now <= 1'b0;
    end else if (accept && in_col == '0) begin
      pj_now <= 1'b0;
      nj_now <= 1'b0;
    end else begin
      if (pj_evt) pj_now <= 1'b1;
      if (nj_evt) nj_now <= 1'b1;
    end
  end

  au4_j1_locator #(
    .PTR_W(PTR_W), .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS),
    .PTR_ROW(PTR_ROW), .ROW_W(ROW_W), .COL_W(COL_W)
  ) loc_i (
    .cur(cur), .j1_row(j1_row), .j1_col(j1_col)
  );

  assign in_pay    = in_col >= COL_W'(TOH_COLS);
  assign pos_stuff = pj_now && in_row == ROW_W'(PTR_ROW) && in_col < COL_W'(TOH_COLS + 3);
  assign neg_opp   = nj_now && in_row == ROW_W'(PTR_ROW) && !in_pay &&
                     in_col >= COL_W'(TOH_COLS - 3);
  assign j1_mark   = accept && in_norm && in_row == j1_row && in_col == j1_col;
  assign spe_mark  = accept && in_norm && ((in_pay && !pos_stuff) || neg_opp);

  assign evt = {ndf_evt, nj_evt, pj_evt};
  assign clr = {rd_ndf, rd_nj, rd_pj};

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    au4_evt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .inc(evt[k]), .clr(clr[k]), .cnt(cnt[k])
    );
  end

  assign pj_cnt   = cnt[0];
  assign nj_cnt   = cnt[1];
  assign ndf_cnt  = cnt[2];
  assign path_ais = (state == ST_AIS);
  assign lop      = (state == ST_LOP);
  assign ptr_out  = cur;
endmodule

// File: rtl/au4_ptr_checker.sv
module au4_ptr_checker #(
  parameter int PTR_W   = 10,
  parameter int MAX_PTR = 782,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             rd_pj,
  input logic             rd_nj,
  input logic             j1_mark,
  input logic             spe_mark,
  input logic             path_ais,
  input logic             lop,
  input logic [PTR_W-1:0] ptr_out,
  input logic [CNT_W-1:0] pj_cnt,
  input logic [CNT_W-1:0] nj_cnt
);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ptr_out) && $stable(lop) && $stable(path_ais));

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !j1_mark && !spe_mark);

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_out <= PTR_W'(MAX_PTR));

  assert_pj_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_pj) && pj_cnt != $past(pj_cnt)) |-> pj_cnt == $past(pj_cnt) + 1'b1);

  assert_ais_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_ais) |-> $past(in_valid) && $past(in_data) == 8'hFF);

  assert_no_j1_alarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lop || path_ais) |-> !j1_mark && !spe_mark);

  assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (&pj_cnt && !rd_pj) |=> &pj_cnt);

  assert_clr_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nj |=> nj_cnt <= CNT_W'(1));
endmodule

bind au4_ptr_tracker au4_ptr_checker #(
  .PTR_W(PTR_W), .MAX_PTR(MAX_PTR), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_data(in_data),
  .rd_pj(rd_pj), .rd_nj(rd_nj), .j1_mark(j1_mark), .spe_mark(spe_mark),
  .path_ais(path_ais), .lop(lop), .ptr_out(ptr_out),
  .pj_cnt(pj_cnt), .nj_cnt(nj_cnt)
);

// File: tb/au4_ptr_tracker_tb_top.sv
module au4_ptr_tracker_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, en, in_valid, in_ready;
  logic [7:0] in_data;
  logic [3:0] in_row;
  logic [8:0] in_col;
  logic       ss_chk_en, ss_sel_prog, ais_lop_dis, rd_pj, rd_nj, rd_ndf;
  logic [1:0] ss_prog;
  logic       j1_mark, spe_mark, path_ais, lop;
  logic [9:0] ptr_out;
  logic [7:0] pj_cnt, nj_cnt, ndf_cnt;

  au4_ptr_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_row(in_row), .in_col(in_col),
    .ss_chk_en(ss_chk_en), .ss_sel_prog(ss_sel_prog), .ss_prog(ss_prog),
    .ais_lop_dis(ais_lop_dis), .rd_pj(rd_pj), .rd_nj(rd_nj), .rd_ndf(rd_ndf),
    .j1_mark(j1_mark), .spe_mark(spe_mark), .path_ais(path_ais), .lop(lop),
    .ptr_out(ptr_out), .pj_cnt(pj_cnt), .nj_cnt(nj_cnt), .ndf_cnt(ndf_cnt)
  );

  int n_chk = 0, n_bad = 0;
  // reference state: 0 normal, 1 AIS, 2 LOP
  int m_st, m_cur, m_cand, m_newc, m_invc, m_aisc, m_pj, m_nj, m_ndf;
  bit m_pjf, m_njf;
  logic sm_j1, sm_spe;
  localparam logic [3:0] NF = 4'b0110, DF = 4'b1001;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkw(logic [3:0] n, logic [1:0] s, int p);
    logic [9:0] pv = 10'(p);
    return {n, s, pv};
  endfunction

  function automatic int w_cls(logic [15:0] w);
    int p = int'(w[9:0]);
    logic [1:0] e = ss_sel_prog ? ss_prog : 2'b10;
    logic [9:0] d;
    int oi, ei;
    if (w == 16'hFFFF) return 1;
    if (ss_chk_en && w[11:10] != e) return 0;
    if ($countones(w[15:12] ^ DF) <= 1) return (p <= 782) ? 5 : 0;
    if ($countones(w[15:12] ^ NF) > 1) return 0;
    if (m_st == 0) begin
      if (p == m_cur) return 2;
      d  = w[9:0] ^ 10'(m_cur);
      oi = $countones(d & 10'h2AA);
      ei = $countones(d & 10'h155);
      if (oi >= 3 && ei < 3) return 3;
      if (ei >= 3 && oi < 3) return 4;
    end
    return (p <= 782) ? 6 : 0;
  endfunction

  task automatic model_step(logic [15:0] w);
    int c = w_cls(w);
    int p = int'(w[9:0]);
    case (c)
      1: begin m_invc = 0; m_newc = 0; if (m_aisc < 3) m_aisc++; if (m_aisc == 3) m_st = 1; end
      0: begin
        m_aisc = 0; m_newc = 0; if (m_invc < 8) m_invc++;
        if (m_invc == 8 && (m_st == 0 || (m_st == 1 && !ais_lop_dis))) m_st = 2;
      end
      2: begin m_invc = 0; m_newc = 0; m_aisc = 0; end
      3: begin m_invc = 0; m_newc = 0; m_aisc = 0; m_cur = (m_cur == 782) ? 0 : m_cur + 1;
               if (m_pj < 255) m_pj++; m_pjf = 1; end
      4: begin m_invc = 0; m_newc = 0; m_aisc = 0; m_cur = (m_cur == 0) ? 782 : m_cur - 1;
               if (m_nj < 255) m_nj++; m_njf = 1; end
      5: begin m_invc = 0; m_newc = 0; m_aisc = 0; m_cur = p; m_st = 0;
               if (m_ndf < 255) m_ndf++; end
      default: begin
        m_invc = 0; m_aisc = 0;
        if (p == m_cand && m_newc != 0) m_newc++; else m_newc = 1;
        m_cand = p;
        if (m_newc == 3) begin m_cur = p; m_st = 0; m_newc = 0; end
      end
    endcase
  endtask

  task automatic put(int r, int c, logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_row = 4'(r); in_col = 9'(c); in_data = d;
    if (en && c == 0) begin m_pjf = 0; m_njf = 0; end
    #1;
    sm_j1  = j1_mark;
    sm_spe = spe_mark;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(string tag);
    chk({tag, " lop"}, int'(lop), int'(m_st == 2));
    chk({tag, " ais"}, int'(path_ais), int'(m_st == 1));
    chk({tag, " ptr"}, int'(ptr_out), m_cur);
    chk({tag, " pj"}, int'(pj_cnt), m_pj);
    chk({tag, " nj"}, int'(nj_cnt), m_nj);
    chk({tag, " ndf"}, int'(ndf_cnt), m_ndf);
  endtask

  task automatic send(logic [15:0] w, string tag);
    put(3, 0, w[15:8]);
    put(3, 3, w[7:0]);
    if (en) model_step(w);
    idle();
    compare(tag);
  endtask

  function automatic int j1_r();
    int l = 3 * m_cur;
    return (3 + l / 261) % 9;
  endfunction
  function automatic int j1_c();
    return 9 + (3 * m_cur) % 261;
  endfunction

  function automatic int exp_spe(int r, int c);
    if (!en || m_st != 0) return 0;
    if (r == 3 && c >= 6 && c < 9 && m_njf) return 1;
    if (c < 9) return 0;
    if (r == 3 && c < 12 && m_pjf) return 0;
    return 1;
  endfunction

  task automatic probe(int r, int c, string tag);
    put(r, c, 8'h5A);
    chk({tag, " j1_mark"}, int'(sm_j1), int'(en && m_st == 0 && r == j1_r() && c == j1_c()));
    chk({tag, " spe_mark"}, int'(sm_spe), exp_spe(r, c));
    idle();
  endtask

  task automatic pulse_rd(int which);
    @(negedge clk);
    rd_pj = (which == 0); rd_nj = (which == 1); rd_ndf = (which == 2);
    @(negedge clk);
    rd_pj = 0; rd_nj = 0; rd_ndf = 0;
    if (which == 0) m_pj = 0;
    if (which == 1) m_nj = 0;
    if (which == 2) m_ndf = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed, rp;
    seed = $urandom(32'h1A2B);
    rst_n = 0; en = 1; in_valid = 0; in_data = 0; in_row = 0; in_col = 0;
    ss_chk_en = 1; ss_sel_prog = 0; ss_prog = 2'b00; ais_lop_dis = 0;
    rd_pj = 0; rd_nj = 0; rd_ndf = 0;
    m_st = 2; m_cur = 0; m_cand = 0; m_newc = 0; m_invc = 0; m_aisc = 0;
    m_pj = 0; m_nj = 0; m_ndf = 0; m_pjf = 0; m_njf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    probe(4, 48, "R1 reset");

    // R3: acquire by three equal candidates
    repeat (3) send(mkw(NF, 2'b10, 100), "R3 acquire");
    probe(4, 48, "R9 J1 at offset 300");
    probe(4, 47, "R9 neighbour");
    probe(3, 5, "R10 overhead column");

    // R4 increment, then stuff bytes
    send(mkw(NF, 2'b10, 100 ^ 10'h2AA), "R4 increment");
    probe(3, 9, "R10 positive stuff");
    probe(3, 12, "R10 after stuff");
    probe(j1_r(), j1_c(), "R9 J1 after increment");
    send(mkw(NF, 2'b10, 101 ^ 10'h155), "R4 decrement");
    probe(3, 7, "R10 negative opportunity");

    // R5 new data flag and wrap
    send(mkw(DF, 2'b10, 500), "R5 new data flag");
    send(mkw(DF, 2'b10, 782), "R5 new data flag top");
    send(mkw(NF, 2'b10, 782 ^ 10'h2AA), "R4 wrap to zero");
    probe(3, 9, "R10 R9 wrap probe");

    // R6 size bits
    ss_chk_en = 0;
    send(mkw(NF, 2'b01, 0), "R6 check disabled");
    ss_chk_en = 1; ss_sel_prog = 1; ss_prog = 2'b01;
    send(mkw(NF, 2'b01, 0), "R6 programmed match");
    send(mkw(NF, 2'b10, 0), "R6 programmed mismatch");
    ss_sel_prog = 0;
    repeat (8) send(mkw(NF, 2'b01, 0), "R7 invalid run");

    // R8 AIS and its exit
    repeat (3) send(mkw(NF, 2'b10, 300), "R3 reacquire");
    repeat (3) send(16'hFFFF, "R8 all ones");
    ais_lop_dis = 1;
    repeat (9) send(mkw(4'b0000, 2'b10, 5), "R8 AIS to LOP blocked");
    ais_lop_dis = 0;
    send(mkw(4'b0000, 2'b10, 5), "R8 AIS to LOP");

    // R2 enable low
    repeat (3) send(mkw(NF, 2'b10, 40), "R3 acquire 40");
    en = 0;
    repeat (3) send(16'hFFFF, "R2 disabled");
    chk("R2 in_ready", int'(in_ready), 0);
    probe(j1_r(), j1_c(), "R2 markers");
    en = 1;

    // R11 saturation and clear
    repeat (260) send(mkw(NF, 2'b10, m_cur ^ 10'h2AA), "R11 saturate");
    pulse_rd(0);
    compare("R11 clear pj");
    pulse_rd(2);
    compare("R11 clear ndf");

    // random mix
    rp = 123;
    for (int i = 0; i < 600; i++) begin
      int k = $urandom % 8;
      logic [1:0] sv = ($urandom % 8 == 0) ? 2'($urandom) : 2'b10;
      logic [15:0] w;
      if ($urandom % 3 == 0) rp = $urandom % 783;
      if ($urandom % 40 == 0) ais_lop_dis = ~ais_lop_dis;
      case (k)
        0: w = mkw(NF, sv, m_cur);
        1: w = mkw(NF, sv, m_cur ^ 10'h2AA);
        2: w = mkw(NF, sv, m_cur ^ 10'h155);
        3: w = 16'hFFFF;
        4: w = mkw(DF, sv, $urandom % 783);
        5: w = mkw(NF, sv, rp);
        6: w = 16'($urandom);
        default: w = mkw(NF, sv, 783 + $urandom % 241);
      endcase
      send(w, "R3 R4 R5 R7 R8 random");
      if (i % 4 == 0) probe(j1_r(), j1_c(), "R9 R10 random J1");
      if (i % 50 == 0) begin
        pulse_rd(1);
        compare("R11 clear nj");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule